// File: doc/BRIEF.md
# SPI Controller Register and Interrupt Unit

This unit is the software-visible face of an SPI master. A 32-bit read/write bus with byte offsets reaches a small register file. The file holds the controller's configuration: the control word, frame width, clock divider, slave-select word and the upper half of the transfer count. The stored fields drive the shift engine directly through dedicated outputs. The unit also forwards live engine status, turns a read of the receive-data offset into a pop strobe, and turns writes to the transmit-data and command offsets into push and command strobes.

The shift engine reports six event pulses. Each pulse latches into a raw interrupt bit that stays set until software writes a one to the matching bit of the clear offset. Four of the raw bits have enables in the control word, and their AND forms the masked view. The OR of the masked view drives the interrupt line. While the soft-reset bit of the control word is set, all raw bits are held clear and the engine enable is forced low.

The bus has no wait states. A read returns data in the same cycle as the request, and a write takes effect at the next rising clock edge.

Top module: `spi_regif`

## Requirements
- R1: After the asynchronous reset the control word reads 0x8000_0000, and every other stored register reads 0. No interrupt bit is set and `irq_o` is low.
- R2: The control word at offset 0x00 is stored whole and reads back unchanged. Its bits drive the outputs as follows: bit 0 drives the enable, bit 1 the master select, bit 24 the clock polarity, bit 25 the clock phase, bit 26 the select mode, bit 28 the divider mode, bit 29 the large-FIFO select and bit 31 the soft reset.
- R3: `frame_count_o` equals the low 16 bits of the register at 0x50 concatenated above control bits 23:8. The register at 0x50 keeps only its low 16 bits.
- R4: Frame width (0x04, 6 bits), clock divider (0x18, 8 bits) and slave select (0x1C, 10 bits) each keep their low bits and read back zero-extended. Each drives its own output.
- R5: A read of 0x08 returns `status_i` zero-extended, unchanged.
- R6: A read of 0x10 returns `rx_data_i` and raises `rx_pop_o` for that cycle. A write to 0x14 raises `tx_push_o` with `tx_data_o` equal to the write data. A write to 0x2C raises `cmd_wr_o` with `cmd_o` equal to the low 8 write bits.
- R7: A pulse on bit k of `evt_i` sets raw bit k, which reads at 0x24. The bit stays set with no further event.
- R8: A write to 0x0C clears each raw bit whose write-data bit is 1 and leaves the other raw bits alone. An event arriving in the same cycle as a clear of its bit wins, and the bit ends set.
- R9: The masked view at 0x20 is built as follows: bit 0 is raw 0 AND control bit 5, bit 1 is raw 1 AND control bit 4, bit 2 is raw 2 AND control bit 6, and bit 3 is raw 3 AND control bit 7. Bits 4 and 5 of the masked view are always 0.
- R10: `irq_o` is high exactly when some masked bit is set.
- R11: While control bit 31 is set, `enable_o` is low, and events leave the raw bits at 0.
- R12: Writes to the read-only offsets 0x08, 0x20 and 0x24 change nothing. The clear, transmit and command offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| status_i | input | 15 | Live engine status |
| rx_data_i | input | 32 | Head of receive FIFO |
| rx_pop_o | output | 1 | Receive FIFO pop strobe |
| tx_push_o | output | 1 | Transmit FIFO push strobe |
| tx_data_o | output | 32 | Data to push |
| cmd_wr_o | output | 1 | Command strobe |
| cmd_o | output | 8 | Command bits |
| evt_i | input | 6 | Interrupt event pulses |
| irq_o | output | 1 | Interrupt request |
| enable_o | output | 1 | Engine enable |
| master_o | output | 1 | Master mode |
| cpol_o | output | 1 | Clock polarity |
| cpha_o | output | 1 | Clock phase |
| ss_mode_o | output | 1 | Select behaviour mode |
| clk_mode_o | output | 1 | Divider mode |
| big_fifo_o | output | 1 | Large FIFO select |
| soft_rst_o | output | 1 | Soft reset active |
| frame_size_o | output | 6 | Frame width |
| clk_div_o | output | 8 | Clock divider |
| slave_sel_o | output | 10 | Slave select word |
| frame_count_o | output | 32 | Transfer frame count |

## Verification
A stuck or wrongly decoded register shows up one cycle after the write. The output it drives differs from the written field, and an immediate read-back disagrees at the next bus read. A wrong raw interrupt bit shows up at the next read of 0x24 or 0x20, and through `irq_o` in the cycle after the event or the clear. The set-versus-clear race and the soft-reset hold can only be seen at the cycle boundary where they happen. The checks therefore read the raw register right after those edges.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_FSZ    = 8'h04;
  localparam logic [7:0] OFF_STAT   = 8'h08;
  localparam logic [7:0] OFF_ICLR   = 8'h0C;
  localparam logic [7:0] OFF_RXD    = 8'h10;
  localparam logic [7:0] OFF_TXD    = 8'h14;
  localparam logic [7:0] OFF_DIV    = 8'h18;
  localparam logic [7:0] OFF_SS     = 8'h1C;
  localparam logic [7:0] OFF_MIS    = 8'h20;
  localparam logic [7:0] OFF_RIS    = 8'h24;
  localparam logic [7:0] OFF_CMD    = 8'h2C;
  localparam logic [7:0] OFF_CNTUP  = 8'h50;

  localparam int B_EN     = 0;
  localparam int B_MST    = 1;
  localparam int B_IE_RX  = 4;
  localparam int B_IE_TX  = 5;
  localparam int B_IE_OVF = 6;
  localparam int B_IE_UND = 7;
  localparam int B_CNT_LO = 8;
  localparam int B_CPOL   = 24;
  localparam int B_CPHA   = 25;
  localparam int B_SSMODE = 26;
  localparam int B_CKMODE = 28;
  localparam int B_BIGF   = 29;
  localparam int B_SRST   = 31;

  localparam logic [31:0] CTRL_RST = 32'h8000_0000;

  typedef struct packed {
    logic ctrl;
    logic fsz;
    logic div;
    logic ss;
    logic cntup;
    logic iclr;
    logic txd;
    logic cmd;
  } wr_sel_t;
endpackage

// File: rtl/spi_regif_cfg.sv
module spi_regif_cfg
  import spi_regif_pkg::*;
#(
  parameter int FSZ_W = 6,
  parameter int DIV_W = 8,
  parameter int SS_W  = 10,
  parameter int UP_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wr_sel_t          wsel_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      ctrl_o,
  output logic [FSZ_W-1:0] fsz_o,
  output logic [DIV_W-1:0] div_o,
  output logic [SS_W-1:0]  ss_o,
  output logic [UP_W-1:0]  up_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= CTRL_RST;
      fsz_o  <= '0;
      div_o  <= '0;
      ss_o   <= '0;
      up_o   <= '0;
    end else begin
      if (wsel_i.ctrl)  ctrl_o <= wdata_i;
      if (wsel_i.fsz)   fsz_o  <= wdata_i[FSZ_W-1:0];
      if (wsel_i.div)   div_o  <= wdata_i[DIV_W-1:0];
      if (wsel_i.ss)    ss_o   <= wdata_i[SS_W-1:0];
      if (wsel_i.cntup) up_o   <= wdata_i[UP_W-1:0];
    end
  end
endmodule

// File: rtl/spi_regif_irq.sv
module spi_regif_irq #(
  parameter int INT_N = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic [INT_N-1:0] evt_i,
  input  logic             clr_we_i,
  input  logic [INT_N-1:0] clr_i,
  input  logic [INT_N-1:0] en_i,
  output logic [INT_N-1:0] raw_o,
  output logic [INT_N-1:0] mis_o,
  output logic             irq_o
);
  for (genvar k = 0; k < INT_N; k++) begin : g_bit
    logic clr_k;
    assign clr_k = clr_we_i & clr_i[k];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     raw_o[k] <= 1'b0;
      else if (srst_i) raw_o[k] <= 1'b0;
      else if (evt_i[k]) raw_o[k] <= 1'b1;  // set wins over clear
      else if (clr_k)  raw_o[k] <= 1'b0;
    end
    assign mis_o[k] = raw_o[k] & en_i[k];
  end

  assign irq_o = |mis_o;
endmodule

// File: rtl/spi_regif_rmux.sv
module spi_regif_rmux
  import spi_regif_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int FSZ_W  = 6,
  parameter int DIV_W  = 8,
  parameter int SS_W   = 10,
  parameter int UP_W   = 16,
  parameter int STAT_W = 15,
  parameter int INT_N  = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       ctrl_i,
  input  logic [FSZ_W-1:0]  fsz_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [SS_W-1:0]   ss_i,
  input  logic [UP_W-1:0]   up_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [31:0]       rxd_i,
  input  logic [INT_N-1:0]  raw_i,
  input  logic [INT_N-1:0]  mis_i,
  output logic [31:0]       rdata_o
);
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFF_CTRL):  rdata_o = ctrl_i;
      ADDR_W'(OFF_FSZ):   rdata_o = 32'(fsz_i);
      ADDR_W'(OFF_STAT):  rdata_o = 32'(stat_i);
      ADDR_W'(OFF_RXD):   rdata_o = rxd_i;
      ADDR_W'(OFF_DIV):   rdata_o = 32'(div_i);
      ADDR_W'(OFF_SS):    rdata_o = 32'(ss_i);
      ADDR_W'(OFF_MIS):   rdata_o = 32'(mis_i);
      ADDR_W'(OFF_RIS):   rdata_o = 32'(raw_i);
      ADDR_W'(OFF_CNTUP): rdata_o = 32'(up_i);
      default:            rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int FSZ_W  = 6,
  parameter int DIV_W  = 8,
  parameter int SS_W   = 10,
  parameter int STAT_W = 15,
  parameter int CMD_W  = 8,
  parameter int INT_N  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [STAT_W-1:0] status_i,
  input  logic [31:0]       rx_data_i,
  output logic              rx_pop_o,
  output logic              tx_push_o,
  output logic [31:0]       tx_data_o,
  output logic              cmd_wr_o,
  output logic [CMD_W-1:0]  cmd_o,
  input  logic [INT_N-1:0]  evt_i,
  output logic              irq_o,
  output logic              enable_o,
  output logic              master_o,
  output logic              cpol_o,
  output logic              cpha_o,
  output logic              ss_mode_o,
  output logic              clk_mode_o,
  output logic              big_fifo_o,
  output logic              soft_rst_o,
  output logic [FSZ_W-1:0]  frame_size_o,
  output logic [DIV_W-1:0]  clk_div_o,
  output logic [SS_W-1:0]   slave_sel_o,
  output logic [31:0]       frame_count_o
);
  localparam int CNT_LO_W = 16;
  localparam int UP_W     = 32 - CNT_LO_W;

  logic              wr, rd;
  wr_sel_t           wsel;
  logic [31:0]       ctrl_q;
  logic [UP_W-1:0]   up_q;
  logic [INT_N-1:0]  raw_q, mis, en_vec;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_comb begin
    wsel       = '0;
    wsel.ctrl  = wr & (addr_i == ADDR_W'(OFF_CTRL));
    wsel.fsz   = wr & (addr_i == ADDR_W'(OFF_FSZ));
    wsel.div   = wr & (addr_i == ADDR_W'(OFF_DIV));
    wsel.ss    = wr & (addr_i == ADDR_W'(OFF_SS));
    wsel.cntup = wr & (addr_i == ADDR_W'(OFF_CNTUP));
    wsel.iclr  = wr & (addr_i == ADDR_W'(OFF_ICLR));
    wsel.txd   = wr & (addr_i == ADDR_W'(OFF_TXD));
    wsel.cmd   = wr & (addr_i == ADDR_W'(OFF_CMD));
  end

  spi_regif_cfg #(
    .FSZ_W(FSZ_W), .DIV_W(DIV_W), .SS_W(SS_W), .UP_W(UP_W)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wsel_i (wsel),
    .wdata_i(wdata_i),
    .ctrl_o (ctrl_q),
    .fsz_o  (frame_size_o),
    .div_o  (clk_div_o),
    .ss_o   (slave_sel_o),
    .up_o   (up_q)
  );

  // enable bits in the control word sit in a different order than the raw bits
  always_comb begin
    en_vec    = '0;
    en_vec[0] = ctrl_q[B_IE_TX];
    en_vec[1] = ctrl_q[B_IE_RX];
    en_vec[2] = ctrl_q[B_IE_OVF];
    en_vec[3] = ctrl_q[B_IE_UND];
  end

  spi_regif_irq #(.INT_N(INT_N)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (ctrl_q[B_SRST]),
    .evt_i   (evt_i),
    .clr_we_i(wsel.iclr),
    .clr_i   (wdata_i[INT_N-1:0]),
    .en_i    (en_vec),
    .raw_o   (raw_q),
    .mis_o   (mis),
    .irq_o   (irq_o)
  );

  spi_regif_rmux #(
    .ADDR_W(ADDR_W), .FSZ_W(FSZ_W), .DIV_W(DIV_W), .SS_W(SS_W),
    .UP_W(UP_W), .STAT_W(STAT_W), .INT_N(INT_N)
  ) u_rmux (
    .addr_i (addr_i),
    .ctrl_i (ctrl_q),
    .fsz_i  (frame_size_o),
    .div_i  (clk_div_o),
    .ss_i   (slave_sel_o),
    .up_i   (up_q),
    .stat_i (status_i),
    .rxd_i  (rx_data_i),
    .raw_i  (raw_q),
    .mis_i  (mis),
    .rdata_o(rdata_o)
  );

  assign rx_pop_o   = rd & (addr_i == ADDR_W'(OFF_RXD));
  assign tx_push_o  = wsel.txd;
  assign tx_data_o  = wdata_i;
  assign cmd_wr_o   = wsel.cmd;
  assign cmd_o      = wdata_i[CMD_W-1:0];

  assign soft_rst_o = ctrl_q[B_SRST];
  assign enable_o   = ctrl_q[B_EN] & ~ctrl_q[B_SRST];
  assign master_o   = ctrl_q[B_MST];
  assign cpol_o     = ctrl_q[B_CPOL];
  assign cpha_o     = ctrl_q[B_CPHA];
  assign ss_mode_o  = ctrl_q[B_SSMODE];
  assign clk_mode_o = ctrl_q[B_CKMODE];
  assign big_fifo_o = ctrl_q[B_BIGF];

  assign frame_count_o = {up_q, ctrl_q[B_CNT_LO +: CNT_LO_W]};
endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk #(
  parameter int ADDR_W = 8,
  parameter int INT_N  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [INT_N-1:0]  evt_i,
  input logic [INT_N-1:0]  raw_q,
  input logic              soft_rst_o,
  input logic              enable_o,
  input logic              irq_o,
  input logic              rx_pop_o,
  input logic              tx_push_o,
  input logic              cmd_wr_o
);
  logic clr_wr;
  assign clr_wr = req_i & we_i & (addr_i == ADDR_W'(8'h0C));

  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_rst_o |=> ((raw_q & $past(evt_i)) == $past(evt_i)))
    else $error("event did not set raw bit");  // R7 R8

  AST_RAW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_wr && !soft_rst_o) |=> ((raw_q & $past(raw_q)) == $past(raw_q)))
    else $error("raw bit dropped without clear");  // R7

  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !soft_rst_o) |=>
      ((raw_q & $past(wdata_i[INT_N-1:0]) & ~$past(evt_i)) == '0))
    else $error("cleared bit still set");  // R8

  AST_SRST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (raw_q == '0))
    else $error("raw set during soft reset");  // R11

  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw_q[3:0] != '0))
    else $error("irq with no raw source");  // R10

  AST_SRST_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> !enable_o)
    else $error("enabled during soft reset");  // R11

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_pop_o, tx_push_o, cmd_wr_o}))
    else $error("multiple strobes");  // R6
endmodule

bind spi_regif spi_regif_chk #(.ADDR_W(ADDR_W), .INT_N(INT_N)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .evt_i     (evt_i),
  .raw_q     (raw_q),
  .soft_rst_o(soft_rst_o),
  .enable_o  (enable_o),
  .irq_o     (irq_o),
  .rx_pop_o  (rx_pop_o),
  .tx_push_o (tx_push_o),
  .cmd_wr_o  (cmd_wr_o)
);

// File: tb/spi_regif_bench.sv
module spi_regif_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [14:0] status_i = '0;
  logic [31:0] rx_data_i = '0;
  logic        rx_pop_o, tx_push_o, cmd_wr_o;
  logic [31:0] tx_data_o;
  logic [7:0]  cmd_o;
  logic [5:0]  evt_i = '0;
  logic        irq_o, enable_o, master_o, cpol_o, cpha_o, ss_mode_o;
  logic        clk_mode_o, big_fifo_o, soft_rst_o;
  logic [5:0]  frame_size_o;
  logic [7:0]  clk_div_o;
  logic [9:0]  slave_sel_o;
  logic [31:0] frame_count_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd_v;
  logic        pop_v;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_regif u_spi_regif (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 rd_v = rdata_o; pop_v = rx_pop_o;
    @(posedge clk_i);
    #1 req_i = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] e);
    @(negedge clk_i);
    evt_i = e;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic t_reset;
    bus_rd(8'h00); check("R1 ctrl", rd_v, 32'h8000_0000);
    bus_rd(8'h24); check("R1 raw", rd_v, 0);
    bus_rd(8'h50); check("R1 upper", rd_v, 0);
    check("R1 irq", irq_o, 0);
  endtask

  task automatic t_soft_reset;
    bus_wr(8'h00, 32'h8000_0001);
    check("R11 enable gated", enable_o, 0);
    check("R2 soft rst out", soft_rst_o, 1);
    pulse(6'h3F);
    bus_rd(8'h24); check("R11 raw held", rd_v, 0);
    bus_wr(8'h00, 32'h0);
  endtask

  task automatic t_ctrl;
    bus_wr(8'h00, 32'h33AB_CD13);
    bus_rd(8'h00); check("R2 readback", rd_v, 32'h33AB_CD13);
    check("R2 fields", {25'd0, enable_o, master_o, cpol_o, cpha_o, ss_mode_o,
                        clk_mode_o, big_fifo_o}, {25'd0, 7'b1111011});
    bus_wr(8'h50, 32'hFFFF_1234);
    bus_rd(8'h50); check("R3 upper trunc", rd_v, 32'h0000_1234);
    check("R3 count", frame_count_o, 32'h1234_ABCD);
  endtask

  task automatic t_fields;
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_rd(8'h04); check("R4 fsz", rd_v, 32'h3F);
    bus_wr(8'h18, 32'h0000_01A5);
    bus_rd(8'h18); check("R4 div", rd_v, 32'hA5);
    bus_wr(8'h1C, 32'hFFFF_F281);
    bus_rd(8'h1C); check("R4 ss", rd_v, 32'h281);
    check("R4 outs", {frame_size_o, clk_div_o, slave_sel_o}, {6'h3F, 8'hA5, 10'h281});
  endtask

  task automatic t_data_path;
    status_i = 15'h5A3C;
    bus_rd(8'h08); check("R5 status", rd_v, 32'h5A3C);
    rx_data_i = 32'hDEAD_BEEF;
    bus_rd(8'h10); check("R6 rx data", rd_v, 32'hDEAD_BEEF);
    check("R6 pop", pop_v, 1);
    @(negedge clk_i); check("R6 pop low", rx_pop_o, 0);
    req_i = 1'b1; we_i = 1'b1; addr_i = 8'h14; wdata_i = 32'hCAFE_0042;
    #1 check("R6 push", {tx_push_o, cmd_wr_o}, 2'b10);
    check("R6 tx data", tx_data_o, 32'hCAFE_0042);
    @(negedge clk_i);
    addr_i = 8'h2C; wdata_i = 32'h0000_010C;
    #1 check("R6 cmd", {cmd_wr_o, tx_push_o, cmd_o}, {2'b10, 8'h0C});
    @(negedge clk_i); req_i = 1'b0; we_i = 1'b0;
    bus_rd(8'h14); check("R12 tx reads 0", rd_v, 0);
  endtask

  task automatic t_irq;
    pulse(6'h3F);
    bus_rd(8'h24); check("R7 raw set", rd_v, 32'h3F);
    bus_rd(8'h20); check("R9 masked rx only", rd_v, 32'h02);
    check("R10 irq", irq_o, 1);
    bus_wr(8'h0C, 32'h02);
    bus_rd(8'h24); check("R8 clear one", rd_v, 32'h3D);
    check("R10 irq low", irq_o, 0);
    bus_rd(8'h0C); check("R12 clr reads 0", rd_v, 0);
    bus_wr(8'h00, 32'h33AB_CDF3);
    bus_rd(8'h20); check("R9 mapping", rd_v, 32'h0D);
    bus_wr(8'h24, 32'h0);
    bus_wr(8'h20, 32'h0);
    bus_wr(8'h08, 32'hFFFF);
    bus_rd(8'h24); check("R12 ro ignored", rd_v, 32'h3D);
    bus_rd(8'h00); check("R12 ctrl intact", rd_v, 32'h33AB_CDF3);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 8'h0C; wdata_i = 32'h3D; evt_i = 6'h01;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; evt_i = '0;
    bus_rd(8'h24); check("R8 set wins", rd_v, 32'h01);
    check("R10 irq from tx done", irq_o, 1);
    bus_wr(8'h0C, 32'h01);
    bus_rd(8'h24); check("R8 final clear", rd_v, 0);
    check("R10 irq off", irq_o, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_soft_reset();
    t_ctrl();
    t_fields();
    t_data_path();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule